// File: doc/BRIEF.md
# Watchdog and Power-Down Reset Controller

This block supervises a processor with a watchdog and decides what kind of reset the watchdog raises. A slow base clock enable drives a prescaler, and the prescaler's carry drives a watchdog counter. When the counter passes its terminal count, the response depends on the processor's state. In normal execution the block raises a full chip reset. While the processor sleeps in its low-power halt state, the block raises only a warm reset of the program counter and stack pointer.

Two status flags let software identify the cause of the last restart. The timeout flag records a watchdog expiry. The power-down flag records that halt was entered. Every restart holds execution off for a fixed oscillator start-up delay, whether it comes from an external reset, a watchdog reset or a wake-up from halt. The watchdog is cleared by software with a single clear strobe, or with a pair of strobes when the pair option is set. Entering halt and the external reset also clear it.

Top module: `wdt_pwr_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `flag_to` and `flag_pd` are cleared, `halted` and both reset pulses are low, and `run_hold` is high. After the last edge with `rst` high, `run_hold` stays high for exactly SST_CYCLES (1024) clock edges.
- R2: The watchdog expires on the 2^PRE_W × 2^CNT_W-th clock edge at which `wdt_clk_en` is high, counted from the last clear. Edges with `wdt_clk_en` low do not advance it.
- R3: An expiry while running gives a one-cycle `chip_rst` pulse, with `flag_to`=1 and `flag_pd`=0, and starts a start-up delay.
- R4: An expiry while halted gives a one-cycle `warm_rst` pulse, with `flag_to`=1 and `flag_pd` unchanged at 1, and starts a start-up delay.
- R5: A `halt_req` while running enters halt on that edge: `halted`=1, `flag_pd`=1, `flag_to`=0, and the watchdog is cleared. Halt entry takes precedence over an expiry on the same edge.
- R6: With `pair_mode`=0, a `sw_clr_a` strobe clears the watchdog and `sw_clr_b` has no effect.
- R7: With `pair_mode`=1, the watchdog is cleared only on the edge where both `sw_clr_a` and `sw_clr_b` have been seen since the last clear. The two may come in either order or on the same edge. A single strobe alone does not clear it.
- R8: A `wake_evt` while halted starts a start-up delay of SST_CYCLES edges, after which execution resumes. `flag_pd` stays 1 and `flag_to` keeps its value. An expiry on the same edge takes precedence.
- R9: During a start-up delay the watchdog is held cleared, and `halt_req` and `wake_evt` are ignored. A `wake_evt` while running is also ignored.
- R10: While `wdt_en` is low, the watchdog never expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | External reset, synchronous, active high |
| wdt_en | input | 1 | Watchdog enable option |
| pair_mode | input | 1 | Option selecting the two-strobe clear |
| wdt_clk_en | input | 1 | One-cycle enable per watchdog base clock period |
| sw_clr_a | input | 1 | Software clear strobe, first half |
| sw_clr_b | input | 1 | Software clear strobe, second half |
| halt_req | input | 1 | Halt-entry strobe |
| wake_evt | input | 1 | Wake-up event from halt |
| chip_rst | output | 1 | One-cycle full chip reset pulse |
| warm_rst | output | 1 | One-cycle program counter and stack pointer reset pulse |
| run_hold | output | 1 | High while execution waits out the start-up delay |
| halted | output | 1 | High while in the halt state |
| flag_to | output | 1 | Timeout status flag |
| flag_pd | output | 1 | Power-down status flag |

## Verification
The expiry time is measured with `wdt_clk_en` held high and with `wdt_clk_en` toggling every other cycle. Comparing the two separates counting of enabled ticks from counting of raw clocks. Clear strobes are timed so that each wrong behaviour moves the reset pulse to a different cycle: a single strobe, a strobe on the ignored line, paired strobes in both orders, and paired strobes on the same edge. Expiries are produced both while running and while halted, which tells the full reset apart from the warm reset and checks the flag pairs for each cause. Halt and wake strobes are also issued during start-up and while running, and the watchdog is run disabled, to show that each of these is ignored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_RUN   = 2'd1,
    PH_HALT  = 2'd2
  } phase_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  generate
    if (PRE_W == 0) begin : g_bypass
      assign tick = en && !clr;
    end else begin : g_div
      logic [PRE_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || clr) div_q <= '0;
        else if (en)    div_q <= div_q + 1'b1;
      end
      assign tick = en && !clr && (&div_q);
    end
  endgenerate
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  // terminal count reached on a step: the counter wraps as it expires
  assign expire = step && !clr && (&cnt_q);
endmodule

// File: rtl/wdt_clear_pair.sv
module wdt_clear_pair (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic pair_mode,
  input  logic clr_a,
  input  logic clr_b,
  output logic fire
);
  logic a_q, b_q;
  logic a_any, b_any;

  assign a_any = a_q || clr_a;
  assign b_any = b_q || clr_b;
  assign fire  = pair_mode ? (a_any && b_any) : clr_a;

  always_ff @(posedge clk) begin
    if (rst || flush || fire || !pair_mode) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_any;
      b_q <= b_any;
    end
  end
endmodule

// File: rtl/wdt_startup.sv
module wdt_startup #(
  parameter int SST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic done
);
  localparam int SST_W = (SST_CYCLES > 1) ? $clog2(SST_CYCLES) : 1;
  localparam logic [SST_W-1:0] LAST = SST_W'(SST_CYCLES - 1);

  logic [SST_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst || !active || done) wait_q <= '0;
    else                        wait_q <= wait_q + 1'b1;
  end

  assign done = active && (wait_q == LAST);
endmodule

// File: rtl/wdt_pwr_ctrl.sv
module wdt_pwr_ctrl #(
  parameter int PRE_W      = 8,
  parameter int CNT_W      = 8,
  parameter int SST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic wdt_en,
  input  logic pair_mode,
  input  logic wdt_clk_en,
  input  logic sw_clr_a,
  input  logic sw_clr_b,
  input  logic halt_req,
  input  logic wake_evt,
  output logic chip_rst,
  output logic warm_rst,
  output logic run_hold,
  output logic halted,
  output logic flag_to,
  output logic flag_pd
);
  import wdt_pkg::*;

  phase_t ph_q;
  logic   chip_q, warm_q, to_q, pd_q;
  logic   wd_live, halt_go, sw_fire, wd_clr, pre_tick, expire, sst_done;

  assign wd_live = wdt_en && (ph_q != PH_START);
  assign halt_go = (ph_q == PH_RUN) && halt_req;
  assign wd_clr  = !wd_live || halt_go || sw_fire;

  wdt_clear_pair u_pair (
    .clk       (clk),
    .rst       (rst),
    .flush     (halt_go || (ph_q == PH_START)),
    .pair_mode (pair_mode),
    .clr_a     (sw_clr_a),
    .clr_b     (sw_clr_b),
    .fire      (sw_fire)
  );

  wdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (wd_clr),
    .en   (wd_live && wdt_clk_en),
    .tick (pre_tick)
  );

  wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (wd_clr),
    .step   (pre_tick),
    .expire (expire)
  );

  wdt_startup #(.SST_CYCLES(SST_CYCLES)) u_sst (
    .clk    (clk),
    .rst    (rst),
    .active (ph_q == PH_START),
    .done   (sst_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_START;
      chip_q <= 1'b0;
      warm_q <= 1'b0;
      to_q   <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      chip_q <= 1'b0;
      warm_q <= 1'b0;
      case (ph_q)
        PH_START: if (sst_done) ph_q <= PH_RUN;
        PH_RUN: begin
          if (halt_go) begin
            ph_q <= PH_HALT;
            pd_q <= 1'b1;
            to_q <= 1'b0;
          end else if (expire) begin
            ph_q   <= PH_START;
            chip_q <= 1'b1;
            to_q   <= 1'b1;
            pd_q   <= 1'b0;
          end
        end
        PH_HALT: begin
          if (expire) begin
            ph_q   <= PH_START;
            warm_q <= 1'b1;
            to_q   <= 1'b1;
          end else if (wake_evt) begin
            ph_q <= PH_START;
          end
        end
        default: ph_q <= PH_START;
      endcase
    end
  end

  assign chip_rst = chip_q;
  assign warm_rst = warm_q;
  assign run_hold = (ph_q == PH_START);
  assign halted   = (ph_q == PH_HALT);
  assign flag_to  = to_q;
  assign flag_pd  = pd_q;
endmodule

// File: rtl/wdt_pwr_ctrl_chk.sv
module wdt_pwr_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic wdt_en,
  input logic halt_req,
  input logic wake_evt,
  input logic chip_rst,
  input logic warm_rst,
  input logic run_hold,
  input logic halted,
  input logic flag_to,
  input logic flag_pd
);
  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(chip_rst && warm_rst));

  p_chip_once_r3: assert property (@(posedge clk) disable iff (rst)
    chip_rst |=> !chip_rst);

  p_chip_flags_r3: assert property (@(posedge clk) disable iff (rst)
    chip_rst |-> (flag_to && !flag_pd && run_hold));

  p_warm_flags_r4: assert property (@(posedge clk) disable iff (rst)
    warm_rst |-> (flag_to && flag_pd && run_hold));

  p_halt_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !run_hold && !halted) |=> (halted && flag_pd && !flag_to));

  p_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (wake_evt && halted) |=> (run_hold && flag_pd && !halted));

  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (run_hold && $past(run_hold)) |-> (!chip_rst && !warm_rst));

  p_start_ignores_r9: assert property (@(posedge clk) disable iff (rst)
    run_hold |=> !halted);

  p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(wdt_en) |-> (!chip_rst && !warm_rst));
endmodule

bind wdt_pwr_ctrl wdt_pwr_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wdt_en   (wdt_en),
  .halt_req (halt_req),
  .wake_evt (wake_evt),
  .chip_rst (chip_rst),
  .warm_rst (warm_rst),
  .run_hold (run_hold),
  .halted   (halted),
  .flag_to  (flag_to),
  .flag_pd  (flag_pd)
);

// File: tb/sim_wdt_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_wdt_pwr_ctrl;
  localparam int PRE_W = 2;
  localparam int CNT_W = 3;
  localparam int SST   = 1024;
  localparam int TOUT  = (1 << PRE_W) * (1 << CNT_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdt_en = 1'b1, pair_mode = 1'b0, wdt_clk_en = 1'b1;
  logic sw_clr_a = 1'b0, sw_clr_b = 1'b0, halt_req = 1'b0, wake_evt = 1'b0;
  logic chip_rst, warm_rst, run_hold, halted, flag_to, flag_pd;

  always #5 clk = ~clk;

  wdt_pwr_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W), .SST_CYCLES(SST)) u0 (
    .clk(clk), .rst(rst), .wdt_en(wdt_en), .pair_mode(pair_mode),
    .wdt_clk_en(wdt_clk_en), .sw_clr_a(sw_clr_a), .sw_clr_b(sw_clr_b),
    .halt_req(halt_req), .wake_evt(wake_evt), .chip_rst(chip_rst),
    .warm_rst(warm_rst), .run_hold(run_hold), .halted(halted),
    .flag_to(flag_to), .flag_pd(flag_pd)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    kind;   // 1 full reset, 2 warm reset, 3 resume
    int    at;
    bit    to;
    bit    pd;
    string req;
  } ev_t;
  ev_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input bit to,
                           input bit pd, input string req);
    ev_t e;
    e.kind = kind; e.at = at; e.to = to; e.pd = pd; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: every observed reset pulse or resume is popped and compared
  logic prev_hold = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      int kind;
      kind = 0;
      if (chip_rst)                   kind = 1;
      else if (warm_rst)              kind = 2;
      else if (prev_hold && !run_hold) kind = 3;
      if (kind != 0) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10", "unexpected event kind", kind, 0);
        end else begin
          ev_t e;
          e = sb.pop_front();
          chk(kind == e.kind, e.req, "event kind", kind, e.kind);
          chk(cyc == e.at, e.req, "event cycle", cyc, e.at);
          chk(flag_to == e.to, e.req, "flag_to", int'(flag_to), int'(e.to));
          chk(flag_pd == e.pd, e.req, "flag_pd", int'(flag_pd), int'(e.pd));
        end
      end
    end
    prev_hold = run_hold;
  end

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // sel: 0 clr_a, 1 clr_b, 2 both clears, 3 halt, 4 wake
  task automatic pulse(input int sel, input int edge_no);
    wait_until(edge_no - 1);
    case (sel)
      0: sw_clr_a = 1'b1;
      1: sw_clr_b = 1'b1;
      2: begin sw_clr_a = 1'b1; sw_clr_b = 1'b1; end
      3: halt_req = 1'b1;
      default: wake_evt = 1'b1;
    endcase
    @(negedge clk);
    sw_clr_a = 1'b0; sw_clr_b = 1'b0; halt_req = 1'b0; wake_evt = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    wait_until(3);
    rst = 1'b0;                      // last reset edge is 3
    // R1: start-up after external reset
    expect_ev(3, 3 + SST, 1'b0, 1'b0, "R1");
    wait_until(4);
    chk(flag_to == 0 && flag_pd == 0, "R1", "flags after reset", {flag_to, flag_pd}, 0);
    chk(run_hold == 1 && halted == 0, "R1", "hold/halted after reset", {run_hold, halted}, 2);

    // R3, R2: expiry in run with the base enable always high
    expect_ev(1, 1027 + TOUT, 1'b1, 1'b0, "R3");
    expect_ev(3, 1059 + SST, 1'b1, 1'b0, "R9");
    wait_until(2083);

    // R6: single clear honoured, second strobe ignored
    pulse(0, 2094);
    pulse(1, 2114);
    expect_ev(1, 2094 + TOUT, 1'b1, 1'b0, "R6");
    expect_ev(3, 2126 + SST, 1'b1, 1'b0, "R9");
    wait_until(3150);

    // R7: pair clear a then b, then a lone a
    pair_mode = 1'b1;
    pulse(0, 3160);
    pulse(1, 3170);
    pulse(0, 3190);
    expect_ev(1, 3170 + TOUT, 1'b1, 1'b0, "R7");
    expect_ev(3, 3202 + SST, 1'b1, 1'b0, "R9");
    wait_until(4226);

    // R7: pair clear b then a, then both on one edge
    pulse(1, 4236);
    pulse(0, 4246);
    pulse(2, 4270);
    expect_ev(1, 4270 + TOUT, 1'b1, 1'b0, "R7");
    expect_ev(3, 4302 + SST, 1'b1, 1'b0, "R9");
    wait_until(5326);
    pair_mode = 1'b0;

    // R5, R4: halt then expiry while halted
    pulse(3, 5340);
    chk(halted == 1 && flag_pd == 1 && flag_to == 0, "R5", "halt entry state",
        {halted, flag_pd, flag_to}, 6);
    expect_ev(2, 5340 + TOUT, 1'b1, 1'b1, "R4");
    expect_ev(3, 5372 + SST, 1'b1, 1'b1, "R9");
    pulse(3, 5380);
    chk(halted == 0 && run_hold == 1, "R9", "halt during start-up", {halted, run_hold}, 1);
    wait_until(6396);

    // R8: wake from halt, then a wake while running is ignored
    pulse(3, 6400);
    chk(flag_to == 0 && flag_pd == 1, "R5", "halt clears timeout", {flag_to, flag_pd}, 1);
    pulse(4, 6410);
    chk(run_hold == 1 && halted == 0, "R8", "wake starts delay", {run_hold, halted}, 2);
    expect_ev(3, 6410 + SST, 1'b0, 1'b1, "R8");
    expect_ev(1, 7434 + TOUT, 1'b1, 1'b0, "R9");
    expect_ev(3, 7466 + SST, 1'b1, 1'b0, "R9");
    pulse(4, 7440);
    chk(run_hold == 0 && halted == 0, "R9", "wake in run ignored", {run_hold, halted}, 0);
    wait_until(8490);

    // R2: base enable high only every other cycle doubles the period
    expect_ev(1, 8492 + 2 * (TOUT - 1), 1'b1, 1'b0, "R2");
    expect_ev(3, 8554 + SST, 1'b1, 1'b0, "R9");
    while (cyc < 8554) begin
      wdt_clk_en = cyc[0];
      @(negedge clk);
    end
    wdt_clk_en = 1'b1;
    wait_until(9578);

    // R10: disabled watchdog never expires, in run or in halt
    wdt_en = 1'b0;
    pulse(3, 9700);
    chk(halted == 1 && flag_pd == 1, "R10", "halt with watchdog off", {halted, flag_pd}, 3);
    pulse(4, 9760);
    expect_ev(3, 9760 + SST, 1'b0, 1'b1, "R10");
    wait_until(10784);
    wdt_en = 1'b1;
    expect_ev(1, 10784 + TOUT, 1'b1, 1'b0, "R10");
    expect_ev(3, 10816 + SST, 1'b1, 1'b0, "R9");
    wait_until(11845);

    // R1: external reset clears both flags
    rst = 1'b1;
    wait_until(11848);
    rst = 1'b0;
    chk(flag_to == 0 && flag_pd == 0, "R1", "flags after second reset", {flag_to, flag_pd}, 0);
    chk(run_hold == 1 && chip_rst == 0 && warm_rst == 0, "R1", "outputs after second reset",
        {run_hold, chip_rst, warm_rst}, 4);
    wait_until(11860);
    chk(sb.size() == 0, "R3", "events left in scoreboard", sb.size(), 0);
    finish_run();
  end
endmodule